// File: doc/BRIEF.md
# Clearable Shift Register with J/K-bar Serial Head

A positive-edge-clocked register of `STAGES` flip-flops (four by default) with two synchronous modes selected by a single control line. In load mode every stage captures its own bit of a parallel word. In shift mode each stage passes its value one position toward the last stage, and the last stage's old value is dropped. During a shift the first stage takes its new value from a J input and an inverted-K input. This lets that stage act as a set/reset, D-type or toggle flip-flop while the rest of the chain shifts.

An active-low asynchronous clear forces every stage to zero and overrides the clock and all other inputs. Every stage is visible on a parallel output bus. The last stage also drives a complemented output. Bit 0 of both the parallel input and the output bus is the first stage, the one fed by the serial pair. Typical uses are serial/parallel conversion and small accumulators.

Top module: `sreg_jk_top`

## Requirements
- R1: While `clr_n` is 0, `q` is all zeros. This happens without waiting for a clock edge and whatever the mode, serial and parallel inputs are.
- R2: On a rising `clk` edge with `clr_n`=1 and `shift_ld`=0 (load), `q` takes the value of `par_d`.
- R3: On a rising edge with `clr_n`=1 and `shift_ld`=1 (shift), each `q[i]` for i≥1 takes the old `q[i-1]`, and the old `q[STAGES-1]` is lost.
- R4: In shift mode, the new `q[0]` follows `{ser_j, ser_kb}`: 00 gives 0, 11 gives 1, 01 keeps the old `q[0]`, 10 gives the inverse of the old `q[0]`.
- R5: `q_last_n` always equals the inverse of `q[STAGES-1]`.
- R6: Between rising edges, with `clr_n`=1, `q` and `q_last_n` hold their values whatever the other inputs do.
- R7: In load mode, `ser_j` and `ser_kb` have no effect on the loaded value.
- R8: When `clr_n` is released between edges, `q` stays zero until the next rising edge. That edge then performs the selected load or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_ld | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| ser_j | input | 1 | J serial input to the first stage |
| ser_kb | input | 1 | Inverted-K serial input to the first stage |
| par_d | input | STAGES | Parallel load word, bit 0 = first stage |
| q | output | STAGES | All stage values, bit 0 = first stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The two functions that can meet in one cycle are the asynchronous clear and a pending load. The clear is applied mid-cycle while load mode is selected with an all-ones word. It is then released before the next edge with the same load still selected. The bench checks that `q` reads zero at once and stays zero until that edge. It then checks that the edge itself loads the word. A behavioural model, fed by a driver through a queue, judges every edge of a long random mix of loads, shifts with all four serial pairs, and clears.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    typedef struct packed {
        logic j;
        logic kb;
    } ser_pair_t;

    // Next value of the first stage during a shift.
    function automatic logic head_next(input ser_pair_t s, input logic cur);
        logic r;
        case ({s.j, s.kb})
            2'b00:   r = 1'b0;
            2'b11:   r = 1'b1;
            2'b01:   r = cur;
            default: r = ~cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sreg_head.sv
`timescale 1ns/1ps
module sreg_head
    import sreg_pkg::*;
(
    input  ser_pair_t ser,
    input  logic      cur,
    output logic      nxt
);
    always_comb nxt = head_next(ser, cur);
endmodule

// File: rtl/sreg_next.sv
`timescale 1ns/1ps
module sreg_next
    import sreg_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  mode_e             mode,
    input  logic              head_bit,
    input  logic [STAGES-1:0] cur,
    input  logic [STAGES-1:0] par,
    output logic [STAGES-1:0] nxt
);
    logic [STAGES-1:0] shift_src;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign shift_src[i] = head_bit;
        end else begin : g_rest
            assign shift_src[i] = cur[i-1];
        end
        assign nxt[i] = (mode == MODE_SHIFT) ? shift_src[i] : par[i];
    end
endmodule

// File: rtl/sreg_jk_top.sv
`timescale 1ns/1ps
module sreg_jk_top
    import sreg_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift_ld,
    input  logic              ser_j,
    input  logic              ser_kb,
    input  logic [STAGES-1:0] par_d,
    output logic [STAGES-1:0] q,
    output logic              q_last_n
);
    localparam int LAST = STAGES - 1;

    mode_e             mode;
    ser_pair_t         ser;
    logic              head_bit;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    assign mode   = mode_e'(shift_ld);
    assign ser.j  = ser_j;
    assign ser.kb = ser_kb;

    sreg_head u_head (
        .ser (ser),
        .cur (stage_q[0]),
        .nxt (head_bit)
    );

    sreg_next #(.STAGES(STAGES)) u_next (
        .mode     (mode),
        .head_bit (head_bit),
        .cur      (stage_q),
        .par      (par_d),
        .nxt      (stage_d)
    );

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q        = stage_q;
    assign q_last_n = ~stage_q[LAST];

    // R1: an edge seen while clear is low finds the register empty
    p_clear_zero_r1: assert property (@(posedge clk) (clr_n === 1'b0) |-> (q == '0));

    // R2: load mode captures the parallel word
    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_ld == 1'b0) |=> (q == $past(par_d)));

    // R3: shift moves each stage one place up
    p_shift_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_ld == 1'b1) |=> (q[LAST:1] == $past(q[LAST-1:0])));

    // R4: toggle and hold pairs on the first stage
    p_toggle_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_ld && ser_j && !ser_kb) |=> (q[0] != $past(q[0])));
    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_ld && !ser_j && ser_kb) |=> (q[0] == $past(q[0])));
endmodule

// File: tb/sim_sreg_jk_top.sv
`timescale 1ns/1ps
module sim_sreg_jk_top;
    localparam int N = 4;

    typedef struct {
        logic [N-1:0] q;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         shift_ld;
    logic         ser_j;
    logic         ser_kb;
    logic [N-1:0] par_d;
    logic [N-1:0] q;
    logic         q_last_n;

    int           checks = 0;
    int           errors = 0;
    logic [N-1:0] model;
    exp_t         sb[$];

    always #2.5 clk = ~clk;

    sreg_jk_top #(.STAGES(N)) u0 (
        .clk(clk), .clr_n(clr_n), .shift_ld(shift_ld), .ser_j(ser_j),
        .ser_kb(ser_kb), .par_d(par_d), .q(q), .q_last_n(q_last_n)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_next(input logic sl, input logic j,
                                                input logic kb, input logic [N-1:0] d,
                                                input logic [N-1:0] cur);
        logic h;
        case ({j, kb})
            2'b00:   h = 1'b0;
            2'b11:   h = 1'b1;
            2'b01:   h = cur[0];
            default: h = ~cur[0];
        endcase
        return sl ? {cur[N-2:0], h} : d;
    endfunction

    // Driver: one rising edge of stimulus per call.
    task automatic step(input logic sl, input logic j, input logic kb,
                        input logic [N-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        shift_ld = sl; ser_j = j; ser_kb = kb; par_d = d;
        #0.5;
        check("R6 hold between edges", q, model);
        model = model_next(sl, j, kb, d, model);
        e.q = model; e.tag = tag;
        sb.push_back(e);
    endtask

    // Clear mid-cycle with a pending all-ones load, release before the edge.
    task automatic clear_pulse();
        exp_t e;
        @(negedge clk);
        shift_ld = 1'b0; par_d = '1; ser_j = 1'b1; ser_kb = 1'b0;
        #1 clr_n = 1'b0;
        #0.5;
        check("R1 async clear", q, '0);
        model = '0;
        e.q = '0; e.tag = "R1 clear over edge";
        sb.push_back(e);
        @(negedge clk);
        #1 clr_n = 1'b1;
        #0.5;
        check("R8 zero after release", q, '0);
        model = '1;
        e.q = '1; e.tag = "R8 first edge after release";
        sb.push_back(e);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, q, e.q);
                checks++;
                if (q_last_n !== ~q[N-1]) begin
                    errors++;
                    $display("FAIL R5 q_last_n actual=%b expected=%b", q_last_n, ~q[N-1]);
                end
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t e;
        clr_n = 1'b0; shift_ld = 1'b0; ser_j = 1'b0; ser_kb = 1'b0; par_d = '1;
        model = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset state", q, '0);
        clr_n = 1'b1;
        #0.5;
        check("R8 held zero after release", q, '0);
        model = '1;
        e.q = '1; e.tag = "R8 edge loads after release";
        sb.push_back(e);

        step(1'b0, 1'b0, 1'b0, 4'b1010, "R2 load 1010");
        step(1'b0, 1'b1, 1'b0, 4'b0110, "R7 load ignores J/K-bar 10");
        step(1'b0, 1'b1, 1'b1, 4'b0001, "R7 load ignores J/K-bar 11");
        step(1'b1, 1'b0, 1'b0, '0, "R3 R4 shift in 0");
        step(1'b1, 1'b1, 1'b1, '0, "R4 shift in 1");
        step(1'b1, 1'b0, 1'b1, '0, "R4 hold head");
        step(1'b1, 1'b1, 1'b0, '0, "R4 toggle head");
        step(1'b1, 1'b1, 1'b0, '0, "R4 toggle head again");
        step(1'b1, 1'b1, 1'b1, '0, "R3 shift last out");
        clear_pulse();
        step(1'b1, 1'b0, 1'b0, '0, "R3 shift after clear");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 19) == 0) clear_pulse();
            else step(1'($urandom), 1'($urandom), 1'($urandom), N'($urandom),
                      "R2 R3 R4 random");
        end

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule